// File: doc/BRIEF.md
# Transition-Signalled Bundled-Data Pipeline

This block is a cycle-based model of a chain of asynchronous pipeline stages that talk to each other with two-phase handshakes. A request or acknowledge is a change of level, not a level: each flip of a wire is one full transaction, and no return-to-zero phase follows it. Every stage has one data register, a small phase controller, and an optional arithmetic step on the data. The outgoing request of a stage waits a configurable number of cycles, standing in for the matched delay of its logic. That way the request never gets ahead of the data it carries.

A producer puts a word on `inData` and flips `inReq`. The block flips `inAck` once the first stage has taken the word. At the far end, `outReq` flips when a word is ready on `outData`. The consumer flips `outAck` to take it. Several stages chained together act as a FIFO that keeps order, and each word has the per-stage increment added once per stage.

Top module: `toggle_pipe`

## Requirements
- R1: While reset is asserted, `inAck`, `outReq` and `outData` are all zero and every stage is empty.
- R2: When the first stage is empty and `inReq` differs from `inAck`, `inAck` takes the value of `inReq` on the next rising clock edge. `inAck` never changes while `inReq` equals `inAck`.
- R3: The chain holds at most STAGES words. If the consumer does not acknowledge, the block accepts exactly STAGES words, and the next request stays unacknowledged for as long as the stall lasts.
- R4: In an empty chain, `outReq` flips on the STAGES*(LAG+1)-th rising edge after a request flip on `inReq`, counting the first edge that samples the new request as edge 1. Each stage holds back its outgoing request for exactly LAG cycles after it captures a word.
- R5: Each word leaves the block as (input + STAGES*STEP) modulo 2^WIDTH. With the defaults (4 stages, STEP 1), that is input + 4.
- R6: Words leave in the order they entered. No word is lost or duplicated, even when the consumer stalls its acknowledge for random periods.
- R7: While `outReq` differs from `outAck`, `outData` does not change.
- R8: `outReq` flips only when it equals `outAck`, so at most one word is offered to the consumer at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Model clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inReq | input | 1 | Producer request; each flip offers one word |
| inData | input | WIDTH | Producer word, held stable until acknowledged |
| inAck | output | 1 | Acknowledge to producer; flips when the first stage takes a word |
| outReq | output | 1 | Request to consumer; flips when a new word is ready |
| outData | output | WIDTH | Word offered to consumer |
| outAck | input | 1 | Consumer acknowledge; flipping it takes the offered word |

## Verification
The hardest situation to reach from the ports is a completely full chain. In that state every stage is closed, a fresh request is pending at the input, and the release of the stall has to ripple back stage by stage without dropping or doubling a word. The bench reaches it by holding the consumer's acknowledge fixed and pushing one more word than the chain can hold. It checks that the extra request stays unanswered, then lets the consumer run and expects all the held words in order. After that, a long run with random stalls at the consumer side mixes bubbles and back-pressure through every stage.

// File: rtl/toggle_pipe_pkg.sv
package toggle_pipe_pkg;
  // Strobes passed from a stage controller to its data register.
  typedef struct packed {
    logic load;   // capture the incoming word this cycle
  } stageStrobeT;
endpackage

// File: rtl/toggle_stage_ctrl.sv
module toggle_stage_ctrl
  import toggle_pipe_pkg::*;
#(
  parameter int LAG = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqIn,
  input  logic        ackNext,
  output logic        done,
  output logic        reqOut,
  output stageStrobeT strobe
);
  logic isOpen;
  logic isFresh;

  // The register is open once the next stage has consumed the word last offered.
  assign isOpen  = (done == ackNext);
  assign isFresh = (reqIn != done);
  assign strobe.load = isOpen && isFresh;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else if (strobe.load) done <= ~done;
  end

  generate
    if (LAG == 0) begin : gNoLag
      assign reqOut = done;
    end else begin : gLag
      localparam int CW = $clog2(LAG + 1);
      logic [CW-1:0] lagCnt;
      logic          outPhase;

      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          lagCnt   <= '0;
          outPhase <= 1'b0;
        end else if (strobe.load) begin
          lagCnt <= CW'(LAG);
        end else if (lagCnt != '0) begin
          lagCnt <= lagCnt - 1'b1;
          if (lagCnt == CW'(1)) outPhase <= done;
        end
      end
      assign reqOut = outPhase;
    end
  endgenerate
endmodule

// File: rtl/toggle_stage_data.sv
module toggle_stage_data
  import toggle_pipe_pkg::*;
#(
  parameter int WIDTH = 8,
  parameter int STEP  = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  stageStrobeT      strobe,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] dataOut
);
  logic [WIDTH-1:0] nextWord;

  generate
    if (STEP == 0) begin : gPass
      assign nextWord = dataIn;
    end else begin : gAdd
      assign nextWord = dataIn + WIDTH'(STEP);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dataOut <= '0;
    else if (strobe.load) dataOut <= nextWord;
  end
endmodule

// File: rtl/toggle_pipe.sv
module toggle_pipe
  import toggle_pipe_pkg::*;
#(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8,
  parameter int LAG    = 2,
  parameter int STEP   = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inReq,
  input  logic [WIDTH-1:0] inData,
  output logic             inAck,
  output logic             outReq,
  output logic [WIDTH-1:0] outData,
  input  logic             outAck
);
  logic             reqChain [STAGES+1];
  logic             ackChain [STAGES+1];
  logic [WIDTH-1:0] dataChain[STAGES+1];

  assign reqChain[0]       = inReq;
  assign dataChain[0]      = inData;
  assign ackChain[STAGES]  = outAck;
  assign inAck             = ackChain[0];
  assign outReq            = reqChain[STAGES];
  assign outData           = dataChain[STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : gStage
    stageStrobeT strobe;

    toggle_stage_ctrl #(.LAG(LAG)) uCtrl (
      .clk    (clk),
      .rstN   (rstN),
      .reqIn  (reqChain[i]),
      .ackNext(ackChain[i+1]),
      .done   (ackChain[i]),
      .reqOut (reqChain[i+1]),
      .strobe (strobe)
    );

    toggle_stage_data #(.WIDTH(WIDTH), .STEP(STEP)) uData (
      .clk    (clk),
      .rstN   (rstN),
      .strobe (strobe),
      .dataIn (dataChain[i]),
      .dataOut(dataChain[i+1])
    );
  end
endmodule

// File: rtl/toggle_pipe_chk.sv
module toggle_pipe_chk #(
  parameter int STAGES = 4,
  parameter int WIDTH  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             inReq,
  input logic             inAck,
  input logic             outReq,
  input logic [WIDTH-1:0] outData,
  input logic             outAck
);
  int   held;
  logic prevInAck;
  logic prevOutAck;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      held       <= 0;
      prevInAck  <= 1'b0;
      prevOutAck <= 1'b0;
    end else begin
      held       <= held + int'(inAck != prevInAck) - int'(outAck != prevOutAck);
      prevInAck  <= inAck;
      prevOutAck <= outAck;
    end
  end

  a_r2_ack_needs_req: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(inAck) |-> ($past(inReq) != $past(inAck)));

  a_r3_no_overfill: assert property (@(posedge clk) disable iff (!rstN)
    held <= STAGES);

  a_r7_data_held: assert property (@(posedge clk) disable iff (!rstN)
    (outReq != outAck) |=> $stable(outData));

  a_r8_one_offer: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outReq) |-> ($past(outReq) == $past(outAck)));
endmodule

bind toggle_pipe toggle_pipe_chk #(.STAGES(STAGES), .WIDTH(WIDTH)) uChk (
  .clk    (clk),
  .rstN   (rstN),
  .inReq  (inReq),
  .inAck  (inAck),
  .outReq (outReq),
  .outData(outData),
  .outAck (outAck)
);

// File: tb/toggle_pipe_test.sv
module toggle_pipe_test;
  localparam int CLK_PERIOD = 10;
  localparam int STAGES = 4;
  localparam int WIDTH  = 8;
  localparam int LAG    = 2;
  localparam int STEP   = 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inReq = 1'b0;
  logic [WIDTH-1:0] inData = '0;
  logic inAck;
  logic outReq;
  logic [WIDTH-1:0] outData;
  logic outAck = 1'b0;

  int checks = 0;
  int failures = 0;
  int sentCnt = 0;
  int gotCnt = 0;
  int stallPct = 0;
  bit stallAll = 1'b0;
  bit finished = 1'b0;
  logic [WIDTH-1:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  toggle_pipe #(.STAGES(STAGES), .WIDTH(WIDTH), .LAG(LAG), .STEP(STEP)) uut (
    .clk(clk), .rstN(rstN), .inReq(inReq), .inData(inData), .inAck(inAck),
    .outReq(outReq), .outData(outData), .outAck(outAck)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic sendItem(input logic [WIDTH-1:0] d);
    while (inReq != inAck) @(negedge clk);
    inData = d;
    expQ.push_back(WIDTH'(d + STAGES * STEP));
    sentCnt++;
    inReq = ~inReq;
  endtask

  task automatic drain();
    while (expQ.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: consumer with optional stalls, compares against the scoreboard.
  always @(negedge clk) begin
    if (rstN && (outReq != outAck) && !stallAll && (int'($urandom % 100) >= stallPct)) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6 unexpected word", int'(outData), -1);
      end else begin
        logic [WIDTH-1:0] want;
        want = expQ.pop_front();
        check(outData == want, "R5/R6 word value and order", int'(outData), int'(want));
      end
      gotCnt++;
      outAck = ~outAck;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic oldOut;
    int cycles;
    repeat (4) @(negedge clk);
    // R1: reset state
    check(inAck == 1'b0, "R1 inAck in reset", int'(inAck), 0);
    check(outReq == 1'b0, "R1 outReq in reset", int'(outReq), 0);
    check(outData == '0, "R1 outData in reset", int'(outData), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(inAck == 1'b0 && outReq == 1'b0, "R1 idle after reset", int'(inAck), 0);

    // R2 and R4: single word through an empty chain
    oldOut = outReq;
    sendItem(8'h10);
    @(posedge clk); #1;
    cycles = 1;
    check(inAck == inReq, "R2 one-cycle capture", int'(inAck), int'(inReq));
    while (outReq == oldOut && cycles < 200) begin
      @(posedge clk); #1;
      cycles++;
    end
    check(cycles == STAGES * (LAG + 1), "R4 request latency", cycles, STAGES * (LAG + 1));
    drain();

    // R3: full chain with consumer stalled
    stallAll = 1'b1;
    for (int i = 0; i < STAGES; i++) sendItem(WIDTH'(8'h20 + i));
    sendItem(8'h7F);
    repeat (40) @(negedge clk);
    check(inAck != inReq, "R3 extra word refused while full", int'(inAck), int'(~inReq));
    check(outReq != outAck, "R3 word offered while stalled", int'(outReq), int'(~outAck));
    check(expQ.size() == STAGES + 1, "R3 scoreboard depth", expQ.size(), STAGES + 1);
    stallAll = 1'b0;
    drain();
    check(inAck == inReq, "R3 extra word taken after release", int'(inAck), int'(inReq));

    // R5 boundary: wrap-around of the per-stage increment
    sendItem(8'hFE);
    sendItem(8'hFF);
    drain();

    // R6: random stalls, back-to-back traffic
    stallPct = 60;
    for (int i = 0; i < 300; i++) sendItem(WIDTH'($urandom));
    drain();
    stallPct = 0;
    for (int i = 0; i < 50; i++) sendItem(WIDTH'(i * 7));
    drain();
    check(gotCnt == sentCnt, "R6 nothing lost or doubled", gotCnt, sentCnt);
    check(expQ.size() == 0, "R6 scoreboard empty", expQ.size(), 0);

    finished = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule